// File: doc/BRIEF.md
# Flash Bad-Block Remapping Table

This block sits in a flash controller and turns the logical block number a host asks for into the physical block that holds it. After reset it walks every physical block once and reads that block's factory bad marker. Each block that reads as good goes to the next free logical number, in rising physical order, until every logical number has a block. The good blocks that are left over become a pool of spares.

At run time the controller tells the table when a program or erase on a logical block has failed. The table marks the physical block behind that logical block as bad and points the logical block at the lowest-numbered spare. If the pool is empty, the logical block loses its mapping and a sticky status flag goes high. The count of mapped logical blocks is always visible, so usable capacity can be seen shrinking as blocks fail. Copying data to the new block is left to the controller.

Top module: `blk_remap_table`

## Requirements
- R1: While reset is held and in the cycle after it is released: `ready` is 0, `scan_req` is 1 with `scan_idx` 0, `lk_valid` is 0, `usable_cnt` is 0 and `no_spare` is 0.
- R2: During the scan, one marker is accepted on each clock edge where `scan_valid` is 1. `scan_idx` holds its value while `scan_valid` is 0 and otherwise rises by one, from 0 up to NUM_PHYS-1. `ready` goes to 1 and `scan_req` goes to 0 on the edge that accepts the marker of the last block. `ready` then stays at 1 until reset.
- R3: A marker value of 1 on `scan_bad` means the block is bad. Good blocks go to logical numbers 0, 1, 2, ... in rising physical order. A block marked bad is never mapped to any logical number.
- R4: When the scan ends, `usable_cnt` equals the smaller of the good-block count and NUM_LOG. Logical numbers that received no block look up as unmapped.
- R5: A lookup request accepted while `ready` is 1 gives `lk_valid` = 1 on the next cycle. `lk_hit` = 1 means `lk_pba` holds the mapped physical block. A logical number that is unmapped, or that is NUM_LOG or above, returns `lk_hit` = 0 with `lk_pba` = 0.
- R6: A lookup requested while `ready` is 0 is refused: `lk_valid` stays 0.
- R7: A failure report on a mapped logical number marks its current physical block bad and remaps the logical number to the lowest-numbered free good block. `usable_cnt` does not change. A block marked bad is never handed out again.
- R8: A failure report on a mapped logical number when no spare remains leaves that logical number unmapped and lowers `usable_cnt` by one. It also sets `no_spare`, which stays at 1 until reset. `usable_cnt` never rises after the scan.
- R9: A failure report has no effect when its logical number is already unmapped, when it is NUM_LOG or above, or when it arrives before `ready`.
- R10: A lookup made in the same cycle as a failure report on the same logical number returns the mapping as it was before the failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_req | output | 1 | Scan wants the marker of block `scan_idx` |
| scan_idx | output | $clog2(NUM_PHYS) | Physical block whose marker is wanted |
| scan_valid | input | 1 | Marker for `scan_idx` is present this cycle |
| scan_bad | input | 1 | Marker value, 1 = factory bad |
| ready | output | 1 | Scan finished, table in service |
| lk_req | input | 1 | Lookup request |
| lk_lba | input | $clog2(NUM_LOG) | Logical block to translate |
| lk_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Logical block is mapped |
| lk_pba | output | $clog2(NUM_PHYS) | Physical block for the lookup |
| fail_valid | input | 1 | A program or erase failed |
| fail_lba | input | $clog2(NUM_LOG) | Logical block whose operation failed |
| usable_cnt | output | $clog2(NUM_LOG+1) | Number of mapped logical blocks |
| no_spare | output | 1 | A failure found the spare pool empty (sticky) |

## Verification
On every cycle the assertions check the scan index stepping, the ready flag holding once set, the gating and one-cycle latency of lookups, the zero output on a miss, the bound on capacity, that capacity never rises after the scan, and that the spare-empty flag stays set. Only the bench scenarios can show which physical block each logical number receives. Those scenarios also cover the choice of the lowest spare, that a retired block never returns, the unmapping once spares run out, the ignored failure reports, and that a lookup made alongside a failure returns the old mapping.

// File: rtl/blk_remap_pkg.sv
package blk_remap_pkg;
    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/blk_remap_spare.sv
// Picks the lowest-numbered physical block that is neither bad nor in use.
module blk_remap_spare #(
    parameter int NUM_PHYS = 16,
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic [NUM_PHYS-1:0] bad_i,
    input  logic [NUM_PHYS-1:0] used_i,
    output logic                found_o,
    output logic [PW-1:0]       idx_o
);
    logic [NUM_PHYS-1:0] free_w;

    always_comb begin
        free_w  = ~bad_i & ~used_i;
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_w[i]) begin
                found_o = 1'b1;
                idx_o   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/blk_remap_lookup.sv
// Registered translation port: result one cycle after an accepted request.
module blk_remap_lookup #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_LOG  = 12,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int LW = $clog2(NUM_LOG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic [LW-1:0]                lba_i,
    input  logic                         ready_i,
    input  logic [NUM_LOG-1:0][PW-1:0]   map_i,
    input  logic [NUM_LOG-1:0]           mapped_i,
    output logic                         valid_o,
    output logic                         hit_o,
    output logic [PW-1:0]                pba_o
);
    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [PW-1:0] pba;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (req_i && ready_i) begin
            out_d.valid = 1'b1;
            if (int'(lba_i) < NUM_LOG) begin
                if (mapped_i[lba_i]) begin
                    out_d.hit = 1'b1;
                    out_d.pba = map_i[lba_i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o = out_q.valid;
    assign hit_o   = out_q.hit;
    assign pba_o   = out_q.pba;
endmodule

// File: rtl/blk_remap_table.sv
// Logical-to-physical block table with power-up scan and failure remap.
module blk_remap_table
    import blk_remap_pkg::*;
#(
    parameter int NUM_PHYS = 16,
    parameter int NUM_LOG  = 12,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int LW = $clog2(NUM_LOG),
    localparam int CW = $clog2(NUM_LOG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          scan_req,
    output logic [PW-1:0] scan_idx,
    input  logic          scan_valid,
    input  logic          scan_bad,
    output logic          ready,
    input  logic          lk_req,
    input  logic [LW-1:0] lk_lba,
    output logic          lk_valid,
    output logic          lk_hit,
    output logic [PW-1:0] lk_pba,
    input  logic          fail_valid,
    input  logic [LW-1:0] fail_lba,
    output logic [CW-1:0] usable_cnt,
    output logic          no_spare
);
    typedef struct packed {
        phase_e                       phase;
        logic [PW-1:0]                idx;
        logic [NUM_PHYS-1:0]          bad;
        logic [NUM_PHYS-1:0]          used;
        logic [NUM_LOG-1:0][PW-1:0]   map;
        logic [NUM_LOG-1:0]           mapped;
        logic [CW-1:0]                usable;
        logic                         no_spare;
    } state_t;

    state_t        s_d, s_q;
    logic          spare_found;
    logic [PW-1:0] spare_idx;
    logic [LW-1:0] fill_idx;

    blk_remap_spare #(.NUM_PHYS(NUM_PHYS)) u_spare (
        .bad_i   (s_q.bad),
        .used_i  (s_q.used),
        .found_o (spare_found),
        .idx_o   (spare_idx)
    );

    assign fill_idx = LW'(s_q.usable);

    always_comb begin
        s_d = s_q;
        if (s_q.phase == PH_SCAN) begin
            if (scan_valid) begin
                s_d.bad[s_q.idx] = scan_bad;
                if (!scan_bad && (int'(s_q.usable) < NUM_LOG)) begin
                    s_d.map[fill_idx]    = s_q.idx;
                    s_d.mapped[fill_idx] = 1'b1;
                    s_d.used[s_q.idx]    = 1'b1;
                    s_d.usable           = s_q.usable + CW'(1);
                end
                if (s_q.idx == PW'(NUM_PHYS - 1)) s_d.phase = PH_RUN;
                else                              s_d.idx   = s_q.idx + PW'(1);
            end
        end else if (fail_valid && (int'(fail_lba) < NUM_LOG)) begin
            if (s_q.mapped[fail_lba]) begin
                s_d.bad[s_q.map[fail_lba]] = 1'b1;
                if (spare_found) begin
                    s_d.map[fail_lba]  = spare_idx;
                    s_d.used[spare_idx] = 1'b1;
                end else begin
                    s_d.mapped[fail_lba] = 1'b0;
                    s_d.usable           = s_q.usable - CW'(1);
                    s_d.no_spare         = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    blk_remap_lookup #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (lk_req),
        .lba_i    (lk_lba),
        .ready_i  (ready),
        .map_i    (s_q.map),
        .mapped_i (s_q.mapped),
        .valid_o  (lk_valid),
        .hit_o    (lk_hit),
        .pba_o    (lk_pba)
    );

    assign ready      = (s_q.phase == PH_RUN);
    assign scan_req   = (s_q.phase == PH_SCAN);
    assign scan_idx   = s_q.idx;
    assign usable_cnt = s_q.usable;
    assign no_spare   = s_q.no_spare;
endmodule

// File: rtl/blk_remap_checks.sv
module blk_remap_checks #(
    parameter int NUM_PHYS = 16,
    parameter int NUM_LOG  = 12,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int LW = $clog2(NUM_LOG),
    localparam int CW = $clog2(NUM_LOG + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_req,
    input logic [PW-1:0] scan_idx,
    input logic          scan_valid,
    input logic          ready,
    input logic          lk_req,
    input logic          lk_valid,
    input logic          lk_hit,
    input logic [PW-1:0] lk_pba,
    input logic [CW-1:0] usable_cnt,
    input logic          no_spare
);
    assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req && scan_valid && (scan_idx != PW'(NUM_PHYS - 1))
        |=> scan_idx == $past(scan_idx) + PW'(1));

    assert_scan_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req && !scan_valid |=> scan_idx == $past(scan_idx));

    assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_scan_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !scan_req);

    assert_lk_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && ready |=> lk_valid);

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_hit |-> lk_pba == '0);

    assert_lk_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $past(ready) && $past(lk_req));

    assert_cap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(usable_cnt) <= NUM_LOG);

    assert_cap_shrink_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && $past(ready) |-> usable_cnt <= $past(usable_cnt));

    assert_spare_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_spare |=> no_spare);
endmodule

bind blk_remap_table blk_remap_checks #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_req   (scan_req),
    .scan_idx   (scan_idx),
    .scan_valid (scan_valid),
    .ready      (ready),
    .lk_req     (lk_req),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_pba     (lk_pba),
    .usable_cnt (usable_cnt),
    .no_spare   (no_spare)
);

// File: tb/tb_blk_remap_table.sv
module tb_blk_remap_table;
    localparam int NP = 16;
    localparam int NL = 12;
    localparam int PW = $clog2(NP);
    localparam int LW = $clog2(NL);
    localparam int CW = $clog2(NL + 1);

    // Scenario A marks blocks 2 and 5 bad: entry = {lba, hit, pba}
    localparam logic [8:0] VEC [16] = '{
        {4'd0,  1'b1, 4'd0},  {4'd1,  1'b1, 4'd1},  {4'd2,  1'b1, 4'd3},
        {4'd3,  1'b1, 4'd4},  {4'd4,  1'b1, 4'd6},  {4'd5,  1'b1, 4'd7},
        {4'd6,  1'b1, 4'd8},  {4'd7,  1'b1, 4'd9},  {4'd8,  1'b1, 4'd10},
        {4'd9,  1'b1, 4'd11}, {4'd10, 1'b1, 4'd12}, {4'd11, 1'b1, 4'd13},
        {4'd12, 1'b0, 4'd0},  {4'd13, 1'b0, 4'd0},  {4'd14, 1'b0, 4'd0},
        {4'd15, 1'b0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_req;
    logic [PW-1:0] scan_idx;
    logic          scan_valid = 1'b0;
    logic          scan_bad = 1'b0;
    logic          ready;
    logic          lk_req = 1'b0;
    logic [LW-1:0] lk_lba = '0;
    logic          lk_valid;
    logic          lk_hit;
    logic [PW-1:0] lk_pba;
    logic          fail_valid = 1'b0;
    logic [LW-1:0] fail_lba = '0;
    logic [CW-1:0] usable_cnt;
    logic          no_spare;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    blk_remap_table #(.NUM_PHYS(NP), .NUM_LOG(NL)) dut (
        .clk(clk), .rst_n(rst_n), .scan_req(scan_req), .scan_idx(scan_idx),
        .scan_valid(scan_valid), .scan_bad(scan_bad), .ready(ready),
        .lk_req(lk_req), .lk_lba(lk_lba), .lk_valid(lk_valid), .lk_hit(lk_hit),
        .lk_pba(lk_pba), .fail_valid(fail_valid), .fail_lba(fail_lba),
        .usable_cnt(usable_cnt), .no_spare(no_spare)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; scan_valid = 1'b0; lk_req = 1'b0; fail_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ready && scan_req && !lk_valid, "R1 in reset", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_req && scan_idx == '0, "R1 scan start", int'(scan_idx), 0);
        chk(!ready && !lk_valid && !no_spare, "R1 flags", int'(ready), 0);
        chk(usable_cnt == '0, "R1 usable", int'(usable_cnt), 0);
    endtask

    task automatic run_scan(input logic [NP-1:0] badmask);
        for (int i = 0; i < NP; i++) begin
            if (i % 2 == 1) begin
                @(negedge clk);
                chk(scan_idx == PW'(i), "R2 stall", int'(scan_idx), i);
            end
            chk(scan_req && scan_idx == PW'(i), "R2 index", int'(scan_idx), i);
            chk(!ready, "R2 not ready yet", int'(ready), 0);
            scan_valid = 1'b1;
            scan_bad   = badmask[i];
            @(negedge clk);
            scan_valid = 1'b0;
        end
        chk(ready && !scan_req, "R2 ready at end", int'(ready), 1);
    endtask

    task automatic lookup(input int lba, input bit exp_hit, input int exp_pba, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_lba = LW'(lba);
        @(negedge clk);
        lk_req = 1'b0;
        chk(lk_valid == 1'b1, req, int'(lk_valid), 1);
        chk(lk_hit == exp_hit, req, int'(lk_hit), int'(exp_hit));
        chk(int'(lk_pba) == (exp_hit ? exp_pba : 0), req, int'(lk_pba), exp_pba);
    endtask

    task automatic report_fail(input int lba);
        @(negedge clk);
        fail_valid = 1'b1; fail_lba = LW'(lba);
        @(negedge clk);
        fail_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R6: lookup during scan is refused; R9: failure before ready ignored
        lk_req = 1'b1; lk_lba = '0; fail_valid = 1'b1; fail_lba = '0;
        @(negedge clk);
        lk_req = 1'b0; fail_valid = 1'b0;
        chk(!lk_valid, "R6 refused before ready", int'(lk_valid), 0);
        chk(usable_cnt == '0 && scan_idx == '0, "R9 fail before ready", int'(usable_cnt), 0);

        run_scan(16'b0000_0000_0010_0100);
        chk(int'(usable_cnt) == 12, "R4 usable after scan", int'(usable_cnt), 12);
        chk(!no_spare, "R4 spares exist", int'(no_spare), 0);

        for (int v = 0; v < 16; v++)
            lookup(int'(VEC[v][8:5]), VEC[v][4], int'(VEC[v][3:0]), "R3 R5 table");

        // R7: two remaps take spares 14 then 15
        report_fail(3);
        lookup(3, 1'b1, 14, "R7 first spare");
        chk(int'(usable_cnt) == 12, "R7 usable kept", int'(usable_cnt), 12);
        report_fail(0);
        lookup(0, 1'b1, 15, "R7 next spare, bad block not reused");

        // R8: spare pool empty
        report_fail(3);
        lookup(3, 1'b0, 0, "R8 unmapped");
        chk(int'(usable_cnt) == 11, "R8 usable drops", int'(usable_cnt), 11);
        chk(no_spare, "R8 no_spare set", int'(no_spare), 1);

        // R9: failures on unmapped or out-of-range numbers
        report_fail(3);
        report_fail(13);
        chk(int'(usable_cnt) == 11, "R9 ignored", int'(usable_cnt), 11);
        lookup(2, 1'b1, 3, "R9 neighbour intact");

        // R10: lookup alongside failure returns old mapping
        @(negedge clk);
        lk_req = 1'b1; lk_lba = LW'(1); fail_valid = 1'b1; fail_lba = LW'(1);
        @(negedge clk);
        lk_req = 1'b0; fail_valid = 1'b0;
        chk(lk_valid && lk_hit && int'(lk_pba) == 1, "R10 old mapping", int'(lk_pba), 1);
        lookup(1, 1'b0, 0, "R10 then unmapped");
        chk(int'(usable_cnt) == 10 && no_spare, "R8 sticky", int'(usable_cnt), 10);

        // Scenario B: only blocks 1, 6, 9 and 14 are good
        do_reset();
        run_scan(~16'b0100_0010_0100_0010);
        chk(int'(usable_cnt) == 4, "R4 few good blocks", int'(usable_cnt), 4);
        lookup(0, 1'b1, 1, "R3 ascending");
        lookup(3, 1'b1, 14, "R3 ascending");
        lookup(4, 1'b0, 0, "R4 unfilled unmapped");
        report_fail(2);
        lookup(2, 1'b0, 0, "R8 no spare at all");
        chk(int'(usable_cnt) == 3 && no_spare, "R8 count", int'(usable_cnt), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule